// File: doc/BRIEF.md
# Scripted Bus Sequencer

A Wishbone classic master that runs a fixed program stored inside the block. Each program word holds an operation code, an address and a data field. The sequencer takes one word at a time and turns it into a bus read, a bus write, a single held-but-idle tick, or a single released tick. When a read is acknowledged, the sequencer compares the returned data with the value carried in the word. It keeps a sticky error flag and records where the first mismatch happened.

The block is meant for bring-up and self-test of bus slaves. The program is a packed constant parameter, so each instance carries its own script. After the last word the master releases the bus and reports completion until the next reset.

Top module: `wbseq_master`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, wb_cyc_o and wb_stb_o are low and done_o, err_o and err_idx_o are zero. Word 0 is presented in the cycle after that.
- R2: A program word is OP_W+ADDR_W+DATA_W bits wide, with ADDR_W+DATA_W equal to 36. The opcode sits in the top 4 bits, the address in the next ADDR_W bits and the data in the low DATA_W bits. Word i occupies bits [i*WORD_W +: WORD_W] of PROGRAM.
- R3: Opcode 0 is a read. wb_cyc_o and wb_stb_o are high, wb_we_o is low and wb_adr_o equals the address field, all held until wb_ack_i. wb_dat_i is compared with the data field only in the acknowledged cycle.
- R4: Opcode 1 is a write. wb_we_o is high and wb_adr_o and wb_dat_o carry the word's fields, held until wb_ack_i.
- R5: Opcode 2 gives exactly one cycle with wb_cyc_o high and wb_stb_o low, after which the next word follows.
- R6: Opcode 3, and any opcode from 4 to 15, gives exactly one cycle with wb_cyc_o and wb_stb_o low. Address and data fields are ignored for opcodes 2 to 15.
- R7: The cycle after an acknowledged transfer already presents the next word. A program therefore takes exactly the sum of (wait states + 1) over its transfers plus one cycle for each other word.
- R8: wb_sel_o is all ones whenever wb_stb_o is high. wb_we_o is never high outside a write transfer.
- R9: A read mismatch sets err_o, which stays set until reset. err_idx_o holds the word index of the first mismatching read, and later mismatches do not change it. Execution continues with the next word.
- R10: After the last word, done_o is high and wb_cyc_o and wb_stb_o are low until reset.
- R11: Reads that return the expected data leave err_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Transfer strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | ADDR_W | Address from current word |
| wb_dat_o | output | DATA_W | Write data from current word |
| wb_sel_o | output | DATA_W/8 | Byte selects |
| wb_dat_i | input | DATA_W | Read data from slave |
| wb_ack_i | input | 1 | Transfer acknowledge |
| done_o | output | 1 | Program finished |
| err_o | output | 1 | Sticky read-mismatch flag |
| err_idx_o | output | $clog2(PROG_LEN+1) | Index of first mismatching read |

## Verification
The assertions assume that wb_ack_i is a known value that rises only in cycles where wb_stb_o is high and lasts one cycle for each transfer. They also assume that wb_dat_i is meaningful only in that acknowledged cycle. The bench slave model keeps to this: it acknowledges only strobed cycles, after a configurable number of wait states, and drives a junk pattern on wb_dat_i while it is stalling. That junk pattern confirms that the comparison looks only at the acknowledged cycle.

// File: rtl/wbseq_pkg.sv
package wbseq_pkg;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned FIELD_W = 36;

  localparam logic [OP_W-1:0] OP_RD    = 4'd0;
  localparam logic [OP_W-1:0] OP_WR    = 4'd1;
  localparam logic [OP_W-1:0] OP_WAIT  = 4'd2;
  localparam logic [OP_W-1:0] OP_DESEL = 4'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_DONE
  } seq_state_e;

  // default 8-word script, word 0 in the low bits
  localparam logic [8*40-1:0] DEFAULT_PROG = {
    40'h0_2_00000055,
    40'h3_0_00000000,
    40'h1_2_00000055,
    40'h0_1_CAFEF00D,
    40'h2_0_00000000,
    40'h0_0_01020304,
    40'h1_1_CAFEF00D,
    40'h1_0_01020304
  };
endpackage

// File: rtl/wbseq_rom.sv
module wbseq_rom
  import wbseq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PROG_LEN = 8,
  parameter int unsigned PC_W     = 4,
  parameter int unsigned WORD_W   = OP_W + ADDR_W + DATA_W,
  parameter logic [PROG_LEN*WORD_W-1:0] PROGRAM = '0
) (
  input  logic [PC_W-1:0]   pc_i,
  output logic [OP_W-1:0]   op_o,
  output logic [ADDR_W-1:0] adr_o,
  output logic [DATA_W-1:0] dat_o
);
  localparam int unsigned SLOTS = 2 ** PC_W;

  logic [WORD_W-1:0] slot [SLOTS];
  logic [WORD_W-1:0] word;

  // pad to a power of two so any pc value indexes a defined slot
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < PROG_LEN) begin : g_used
      assign slot[g] = PROGRAM[g*WORD_W +: WORD_W];
    end else begin : g_pad
      assign slot[g] = '0;
    end
  end

  assign word  = slot[pc_i];
  assign op_o  = word[WORD_W-1 -: OP_W];
  assign adr_o = word[DATA_W +: ADDR_W];
  assign dat_o = word[DATA_W-1:0];
endmodule

// File: rtl/wbseq_ctrl.sv
module wbseq_ctrl
  import wbseq_pkg::*;
#(
  parameter int unsigned PROG_LEN = 8,
  parameter int unsigned PC_W     = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic            ack_i,
  output logic            cyc_o,
  output logic            stb_o,
  output logic            we_o,
  output logic            done_o,
  output logic            rd_ack_o,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] LAST = PC_W'(PROG_LEN - 1);

  seq_state_e      st_q, st_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            exec, is_rd, is_wr, is_wait, is_xfer, step;

  always_comb begin
    is_rd   = (op_i == OP_RD);
    is_wr   = (op_i == OP_WR);
    is_wait = (op_i == OP_WAIT);
    is_xfer = is_rd | is_wr;
    exec    = (st_q == ST_EXEC);
    // transfers wait for ack, every other opcode takes one tick
    step    = exec && (is_xfer ? ack_i : 1'b1);
    st_d    = st_q;
    pc_d    = pc_q;
    case (st_q)
      ST_IDLE: st_d = ST_EXEC;
      ST_EXEC: begin
        if (step) begin
          pc_d = pc_q + PC_W'(1);
          if (pc_q == LAST) st_d = ST_DONE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      pc_q <= '0;
    end else begin
      st_q <= st_d;
      pc_q <= pc_d;
    end
  end

  assign cyc_o    = exec && (is_xfer || is_wait);
  assign stb_o    = exec && is_xfer;
  assign we_o     = exec && is_wr;
  assign done_o   = (st_q == ST_DONE);
  assign rd_ack_o = exec && is_rd && ack_i;
  assign pc_o     = pc_q;

  AST_STB_NEEDS_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> cyc_o); // R3
  AST_HOLD_TO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o && !ack_i |=> stb_o && $stable(pc_o) && $stable(we_o)); // R4
  AST_ADVANCE_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o && ack_i |=> pc_o == $past(pc_o) + PC_W'(1)); // R7
  AST_WAIT_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_o && !stb_o |=> pc_o == $past(pc_o) + PC_W'(1)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o); // R10
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cyc_o && !stb_o); // R10
endmodule

// File: rtl/wbseq_chk.sv
module wbseq_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PC_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              err_o,
  output logic [PC_W-1:0]   err_idx_o
);
  logic            err_q;
  logic [PC_W-1:0] idx_q;
  logic            miss;

  assign miss = rd_ack_i && (dat_i != exp_i);

  // first failure wins; later mismatches leave the index alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      idx_q <= '0;
    end else if (miss && !err_q) begin
      err_q <= 1'b1;
      idx_q <= pc_i;
    end
  end

  assign err_o     = err_q;
  assign err_idx_o = idx_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && $stable(err_idx_o)); // R9
  AST_FLAG_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack_i && (dat_i != exp_i) |=> err_o); // R9
endmodule

// File: rtl/wbseq_master.sv
module wbseq_master
  import wbseq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PROG_LEN = 8,
  parameter logic [PROG_LEN*(OP_W+ADDR_W+DATA_W)-1:0] PROGRAM = DEFAULT_PROG
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  output logic                         wb_cyc_o,
  output logic                         wb_stb_o,
  output logic                         wb_we_o,
  output logic [ADDR_W-1:0]            wb_adr_o,
  output logic [DATA_W-1:0]            wb_dat_o,
  output logic [DATA_W/8-1:0]          wb_sel_o,
  input  logic [DATA_W-1:0]            wb_dat_i,
  input  logic                         wb_ack_i,
  output logic                         done_o,
  output logic                         err_o,
  output logic [$clog2(PROG_LEN+1)-1:0] err_idx_o
);
  localparam int unsigned WORD_W = OP_W + ADDR_W + DATA_W;
  localparam int unsigned PC_W   = $clog2(PROG_LEN + 1);
  localparam int unsigned SEL_W  = DATA_W / 8;

  if (ADDR_W + DATA_W != FIELD_W) begin : g_bad_split
    $error("address plus data width must be 36");
  end

  logic [PC_W-1:0]   pc;
  logic [OP_W-1:0]   op;
  logic [DATA_W-1:0] field_dat;
  logic              stb, rd_ack;

  wbseq_rom #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_LEN(PROG_LEN),
    .PC_W(PC_W), .WORD_W(WORD_W), .PROGRAM(PROGRAM)
  ) u_rom (
    .pc_i (pc),
    .op_o (op),
    .adr_o(wb_adr_o),
    .dat_o(field_dat)
  );

  wbseq_ctrl #(.PROG_LEN(PROG_LEN), .PC_W(PC_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .ack_i   (wb_ack_i),
    .cyc_o   (wb_cyc_o),
    .stb_o   (stb),
    .we_o    (wb_we_o),
    .done_o  (done_o),
    .rd_ack_o(rd_ack),
    .pc_o    (pc)
  );

  wbseq_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_ack_i (rd_ack),
    .dat_i    (wb_dat_i),
    .exp_i    (field_dat),
    .pc_i     (pc),
    .err_o    (err_o),
    .err_idx_o(err_idx_o)
  );

  assign wb_stb_o = stb;
  assign wb_dat_o = field_dat;
  assign wb_sel_o = {SEL_W{stb}};

  AST_WE_IN_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_we_o |-> wb_stb_o && wb_cyc_o); // R8
  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !wb_cyc_o); // R1
endmodule

// File: tb/wbseq_master_test.sv
module wbseq_master_test;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;
  localparam int PROG_LEN = 11;
  localparam int WORD_W   = 40;
  localparam int PC_W     = $clog2(PROG_LEN + 1);

  // word i at bits [i*40 +: 40]; listed last to first
  localparam logic [PROG_LEN*WORD_W-1:0] PROG = {
    40'hF_9_11111111,  // 10 unused opcode -> released tick
    40'h0_3_0000A5A5,  // 9  read
    40'h1_3_0000A5A5,  // 8  write
    40'h2_5_FFFFFFFF,  // 7  wait (fields ignored)
    40'h2_0_00000000,  // 6  wait
    40'h0_7_12345678,  // 5  read
    40'h3_6_ABCDABCD,  // 4  deselect (fields ignored)
    40'h0_3_DEADBEEF,  // 3  read
    40'h2_0_00000000,  // 2  wait
    40'h1_7_12345678,  // 1  write
    40'h1_3_DEADBEEF   // 0  write
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wb_cyc_o, wb_stb_o, wb_we_o;
  logic [ADDR_W-1:0] wb_adr_o;
  logic [DATA_W-1:0] wb_dat_o;
  logic [DATA_W/8-1:0] wb_sel_o;
  logic [DATA_W-1:0] wb_dat_i = '0;
  logic              wb_ack_i = 1'b0;
  logic              done_o, err_o;
  logic [PC_W-1:0]   err_idx_o;

  wbseq_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_LEN(PROG_LEN), .PROGRAM(PROG)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
    .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel_o),
    .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i),
    .done_o(done_o), .err_o(err_o), .err_idx_o(err_idx_o)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // slave model state
  logic [DATA_W-1:0] mem [16];
  int  lat = 0;
  int  corrupt_mode = 0;
  bit  log_en = 1'b0;
  int  tick_cnt = 0;
  int  bus_viol = 0;
  int  ev_n = 0;
  int  ev_kind [64];
  logic [ADDR_W-1:0] ev_adr [64];
  logic [DATA_W-1:0] ev_dat [64];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic log_ev(input int k, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    if (ev_n < 64) begin
      ev_kind[ev_n] = k;
      ev_adr[ev_n]  = a;
      ev_dat[ev_n]  = d;
    end
    ev_n++;
  endtask

  // kinds: 0 read, 1 write, 2 wait tick, 3 released tick
  task automatic slave_loop();
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (wb_cyc_o && wb_stb_o) begin
        if (wb_sel_o != '1) bus_viol++;
        if (cnt >= lat) begin
          wb_ack_i = 1'b1;
          cnt = 0;
          if (wb_we_o) begin
            mem[wb_adr_o] = wb_dat_o;
            if (log_en) log_ev(1, wb_adr_o, wb_dat_o);
          end else begin
            logic [DATA_W-1:0] d;
            d = mem[wb_adr_o];
            if (corrupt_mode == 2 || (corrupt_mode == 1 && wb_adr_o == 4'd7))
              d = d ^ 32'h0000_0100;
            wb_dat_i = d;
            if (log_en) log_ev(0, wb_adr_o, '0);
          end
        end else begin
          wb_ack_i = 1'b0;
          wb_dat_i = 32'hBAD0_0000;
          cnt++;
        end
      end else begin
        wb_ack_i = 1'b0;
        cnt = 0;
        if (wb_we_o) bus_viol++;
        if (log_en && !done_o) log_ev(wb_cyc_o ? 2 : 3, '0, '0);
      end
      if (log_en && !done_o) tick_cnt++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    ev_n = 0; tick_cnt = 0; bus_viol = 0; log_en = 1'b0;
    repeat (2) @(negedge clk);
    check(!wb_cyc_o && !wb_stb_o && !done_o && !err_o && err_idx_o == 0,
          "R1", "outputs in reset", {wb_cyc_o, wb_stb_o, done_o, err_o}, 0);
    rst_ni = 1'b1;
    #2;
    check(!wb_cyc_o && !wb_stb_o, "R1", "idle cycle after release",
          {wb_cyc_o, wb_stb_o}, 0);
    @(posedge clk);
    log_en = 1'b1;
  endtask

  // full program run with given slave latency and corruption mode
  task automatic t_run(input int l, input int mode, input bit exp_err,
                       input int exp_idx, input string tag);
    int exp_ticks = 0;
    int n_exp = 0;
    lat = l;
    corrupt_mode = mode;
    do_reset();
    while (!done_o) @(negedge clk);
    log_en = 1'b0;
    for (int i = 0; i < PROG_LEN; i++) begin
      logic [3:0] op;
      op = PROG[i*WORD_W + 36 +: 4];
      exp_ticks += (op <= 4'd1) ? l + 1 : 1;
      n_exp++;
    end
    check(ev_n == n_exp, "R2", {tag, " event count"}, ev_n, n_exp);
    for (int i = 0; i < PROG_LEN && i < ev_n; i++) begin
      logic [3:0] op;
      logic [3:0] a;
      logic [31:0] d;
      int k;
      op = PROG[i*WORD_W + 36 +: 4];
      a  = PROG[i*WORD_W + 32 +: 4];
      d  = PROG[i*WORD_W +: 32];
      k  = (op == 4'd0) ? 0 : (op == 4'd1) ? 1 : (op == 4'd2) ? 2 : 3;
      if (k == 0)
        check(ev_kind[i] == 0 && ev_adr[i] == a, "R3", {tag, " read event"},
              {ev_kind[i][3:0], ev_adr[i]}, {4'd0, a});
      else if (k == 1)
        check(ev_kind[i] == 1 && ev_adr[i] == a && ev_dat[i] == d, "R4",
              {tag, " write event"}, {ev_kind[i][3:0], ev_adr[i], ev_dat[i]},
              {4'd1, a, d});
      else if (k == 2)
        check(ev_kind[i] == 2, "R5", {tag, " wait tick"}, ev_kind[i], 2);
      else
        check(ev_kind[i] == 3, "R6", {tag, " released tick"}, ev_kind[i], 3);
    end
    check(tick_cnt == exp_ticks, "R7", {tag, " cycles to done"}, tick_cnt, exp_ticks);
    check(bus_viol == 0, "R8", {tag, " select/write-enable violations"}, bus_viol, 0);
    check(err_o == exp_err, exp_err ? "R9" : "R11", {tag, " error flag"}, err_o, exp_err);
    if (exp_err)
      check(err_idx_o == PC_W'(exp_idx), "R9", {tag, " first failing index"},
            err_idx_o, exp_idx);
    begin
      bit quiet = 1'b1;
      repeat (8) begin
        @(negedge clk);
        if (!done_o || wb_cyc_o || wb_stb_o) quiet = 1'b0;
      end
      check(quiet, "R10", {tag, " done holds with bus released"},
            {done_o, wb_cyc_o, wb_stb_o}, 3'b100);
    end
  endtask

  // reset in the middle of a failing run clears everything
  task automatic t_mid_reset();
    lat = 0;
    corrupt_mode = 2;
    do_reset();
    while (!err_o) @(negedge clk);
    check(!done_o, "R9", "execution continues after mismatch", done_o, 0);
    rst_ni = 1'b0;
    #1;
    check(!wb_cyc_o && !err_o && !done_o && err_idx_o == 0, "R1",
          "async reset mid-run", {wb_cyc_o, err_o, done_o, err_idx_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    log_en = 1'b0;
  endtask

  initial begin
    fork slave_loop(); join_none
    t_run(0, 0, 1'b0, 0, "lat0 clean");
    t_run(2, 0, 1'b0, 0, "lat2 clean");
    t_run(1, 1, 1'b1, 5, "lat1 addr7 bad");
    t_run(0, 2, 1'b1, 3, "lat0 all bad");
    t_mid_reset();
    t_run(3, 0, 1'b0, 0, "lat3 after reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule